// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an 8-bit up-counter fed by a selectable clock divider, with two compare channels. Each channel compares its own register with the running count. On a match it raises a sticky flag and drives its waveform pin by a per-channel action. The count can run freely and roll over, or return to zero after it equals the channel A compare value. With a toggling pin, the second mode gives a square wave at clk / (2 × divide × (1 + compare A)).

Software reaches the block through a single-cycle register write port and a combinational read port. Writing the clock-select field starts the timer, stops it, or resynchronises the divider. There is no separate run bit.

The divider holds a two-state controller, `PS_IDLE` and `PS_RUN`. Transition START goes from `PS_IDLE` to `PS_RUN` when an active select code (1 to 5) is written. Transition STOP goes from `PS_RUN` to `PS_IDLE` when an inactive code (0, 6, 7) is written. Transition RESELECT stays in `PS_RUN` and clears the divider when a different active code is written. Writing the code already held changes nothing.

Top module: `cmp_timer8`

## Requirements
- R1: After reset every register reads 0 (control at address 0, count at 1, compare A at 2, compare B at 3, flags at 4), both pins drive 0 with their enables low, and both flags are 0.
- R2: While the select field (control bits [2:0]) holds 0, 6 or 7, the count does not change.
- R3: Select codes 1, 2, 3, 4, 5 advance the count once every 1, 8, 64, 256, 1024 clocks. After a write that changes the code, the first advance happens at the Nth rising edge after the write edge, where N is the divide ratio.
- R4: With the mode bit (control bit 3) at 0, the count is never cleared by a match and rolls over from 0xFF to 0x00.
- R5: With the mode bit at 1, an advance taken while the count equals compare A loads 0, giving a period of compare A + 1 advances. A compare B match never alters the count.
- R6: Action code 1 toggles the pin on every match of its channel, so the pin changes every divide × (1 + compare A) clocks in mode 1.
- R7: Action code 2 drives the pin to 0 on a match, and code 3 drives it to 1. Channel A's action is control bits [5:4] and channel B's is bits [7:6].
- R8: Action code 0 drops the pin's enable output, and the pin level holds its value.
- R9: A match sets the channel flag (flags bit 0 for A, bit 1 for B). Writing 1 to a flag bit clears it. If a set and a clear fall in the same cycle, the set wins.
- R10: A software write to the count takes effect at its edge and overrides an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| wave_out | output | 2 | Waveform pins, bit 0 channel A, bit 1 channel B |
| wave_oe | output | 2 | Pin enables, high when an action is selected |
| match_flag | output | 2 | Sticky match flags |

## Verification
The assertions assume that reset is applied before the first write. They also assume that software never writes the count in the same cycle as a property's antecedent. The count properties therefore all exclude cycles in which `wr_en` targets the count.

The stimulus changes the select code, the mode and the compare values only while the timer is stopped. The one exception is the directed override case. Random runs draw compare A from 0 to 12 and the divide ratio from 1 or 8, so every measured half-period fits well inside the watchdog.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

    localparam int DIV_W = 10;
    localparam int SEL_W = 3;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } wave_act_e;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_COUNT = 3'd1;
    localparam logic [2:0] REG_CMPA  = 3'd2;
    localparam logic [2:0] REG_CMPB  = 3'd3;
    localparam logic [2:0] REG_FLAGS = 3'd4;

    function automatic logic sel_active(input logic [SEL_W-1:0] s);
        return (s >= 3'd1) && (s <= 3'd5);
    endfunction

    // low-bit mask whose all-ones pattern marks an advance
    function automatic logic [DIV_W-1:0] sel_mask(input logic [SEL_W-1:0] s);
        logic [DIV_W-1:0] m;
        unique case (s)
            3'd2:    m = DIV_W'(10'h007);
            3'd3:    m = DIV_W'(10'h03f);
            3'd4:    m = DIV_W'(10'h0ff);
            3'd5:    m = DIV_W'(10'h3ff);
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cmp_timer_prescale.sv
module cmp_timer_prescale
    import cmp_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_wr,
    input  logic [SEL_W-1:0] sel_new,
    output logic [SEL_W-1:0] sel_q,
    output logic             tick
);

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_RUN  = 2'd1
    } ps_state_e;

    ps_state_e        state, state_nxt;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] low_mask;
    logic             reselect;

    assign reselect = sel_wr && (sel_new != sel_q);
    assign low_mask = sel_mask(sel_q);

    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_IDLE: if (reselect && sel_active(sel_new))  state_nxt = PS_RUN;   // START
            PS_RUN:  if (reselect && !sel_active(sel_new)) state_nxt = PS_IDLE;  // STOP / RESELECT stays
            default: state_nxt = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            sel_q <= '0;
            div_q <= '0;
        end else begin
            state <= state_nxt;
            if (reselect) begin
                sel_q <= sel_new;
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    always_comb begin
        tick = 1'b0;
        unique case (state)
            PS_RUN:  tick = ((div_q & low_mask) == low_mask);
            default: tick = 1'b0;
        endcase
    end

    a_r2_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_active(sel_q) |-> !tick);
    a_r3_div1_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'd1) |-> tick);
    a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        reselect |=> (div_q == '0));

endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic                         clr_on_a,
    input  logic                         cnt_we,
    input  logic [CNT_W-1:0]             cnt_wdata,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]             cnt,
    output logic [NUM_CH-1:0]            hit
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = cnt;
        if (cnt_we)
            cnt_nxt = cnt_wdata;
        else if (tick)
            cnt_nxt = (clr_on_a && (cnt == cmp[0])) ? '0 : cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hit
        assign hit[ch] = tick && (cnt == cmp[ch]);
    end

    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_we) |=> $stable(cnt));
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && !clr_on_a && cnt == CNT_TOP) |=> (cnt == '0));
    a_r5_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_we && clr_on_a && cnt == cmp[0]) |=> (cnt == '0));
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt == $past(cnt_wdata)));

endmodule

// File: rtl/cmp_timer_wave.sv
module cmp_timer_wave
    import cmp_timer_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hit,
    input  wave_act_e act,
    input  logic      flag_clr,
    output logic      wave,
    output logic      oe,
    output logic      flag
);

    logic wave_nxt;

    always_comb begin
        wave_nxt = wave;
        if (hit) begin
            unique case (act)
                ACT_TOGGLE: wave_nxt = ~wave;
                ACT_CLEAR:  wave_nxt = 1'b0;
                ACT_SET:    wave_nxt = 1'b1;
                default:    wave_nxt = wave;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wave <= 1'b0;
            flag <= 1'b0;
        end else begin
            wave <= wave_nxt;
            if (hit)           flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    assign oe = (act != ACT_NONE);

    a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_TOGGLE) |=> (wave != $past(wave)));
    a_r7_set: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_SET) |=> wave);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == ACT_CLEAR) |=> !wave);
    a_r8_hold_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(wave));
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

endmodule

// File: rtl/cmp_timer8.sv
module cmp_timer8
    import cmp_timer_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [2:0]        rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic [NUM_CH-1:0] wave_out,
    output logic [NUM_CH-1:0] wave_oe,
    output logic [NUM_CH-1:0] match_flag
);

    localparam int ACT_LSB = 4;

    logic                         mode_q;
    wave_act_e                    act_q [NUM_CH];
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
    logic [SEL_W-1:0]             sel_q;
    logic [CNT_W-1:0]             cnt;
    logic [NUM_CH-1:0]            hit;
    logic                         tick;
    logic                         wr_ctrl, wr_cnt, wr_flags;

    assign wr_ctrl  = wr_en && (wr_addr == REG_CTRL);
    assign wr_cnt   = wr_en && (wr_addr == REG_COUNT);
    assign wr_flags = wr_en && (wr_addr == REG_FLAGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) mode_q <= wr_data[3];
            if (wr_en && wr_addr == REG_CMPA) cmp_q[0] <= wr_data;
            if (wr_en && wr_addr == REG_CMPB) cmp_q[1] <= wr_data;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       act_q[ch] <= ACT_NONE;
            else if (wr_ctrl) act_q[ch] <= wave_act_e'(wr_data[ACT_LSB+2*ch +: 2]);
        end

        cmp_timer_wave u_wave (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit      (hit[ch]),
            .act      (act_q[ch]),
            .flag_clr (wr_flags && wr_data[ch]),
            .wave     (wave_out[ch]),
            .oe       (wave_oe[ch]),
            .flag     (match_flag[ch])
        );
    end

    cmp_timer_prescale u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_wr  (wr_ctrl),
        .sel_new (wr_data[SEL_W-1:0]),
        .sel_q   (sel_q),
        .tick    (tick)
    );

    cmp_timer_count #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .clr_on_a  (mode_q),
        .cnt_we    (wr_cnt),
        .cnt_wdata (wr_data),
        .cmp       (cmp_q),
        .cnt       (cnt),
        .hit       (hit)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            REG_CTRL:  rd_data = CNT_W'({act_q[1], act_q[0], mode_q, sel_q});
            REG_COUNT: rd_data = cnt;
            REG_CMPA:  rd_data = cmp_q[0];
            REG_CMPB:  rd_data = cmp_q[1];
            REG_FLAGS: rd_data = CNT_W'(match_flag);
            default:   rd_data = '0;
        endcase
    end

    a_r5_b_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && !hit[0] && !wr_cnt) |=> (cnt != '0 || $past(cnt) == '1));
    a_r8_oe_follows_action: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q[0] == ACT_NONE) |-> !wave_oe[0]);

endmodule

// File: tb/cmp_timer8_test.sv
module cmp_timer8_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] wave_out, wave_oe, match_flag;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cmp_timer8 uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wave_out(wave_out), .wave_oe(wave_oe), .match_flag(match_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic int div_of(input int code);
        case (code)
            1: return 1;    2: return 8;    3: return 64;
            4: return 256;  5: return 1024; default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] mk_ctrl(input int sel, input int mode, input int aa, input int ab);
        return 8'(sel | (mode << 3) | (aa << 4) | (ab << 6));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 reg", d, 0);
        end
        chk("R1 oe", wave_oe, 0);
        chk("R1 wave", wave_out, 0);
        chk("R1 flags", match_flag, 0);

        // R2 stopped with code 0
        wr(1, 8'h33);
        repeat (20) @(negedge clk);
        rd(1, d); chk("R2 code0 hold", d, 8'h33);

        // R2 codes 6 and 7 also stop
        wr(0, 8'd6);
        repeat (40) @(negedge clk);
        rd(1, d); chk("R2 code6 hold", d, 8'h33);
        wr(0, 8'd7);
        repeat (40) @(negedge clk);
        rd(1, d); chk("R2 code7 hold", d, 8'h33);

        // R3 divide ratios and first-advance timing
        for (int code = 1; code <= 5; code++) begin
            wr(0, 8'd0);
            wr(1, 8'd0);
            wr(0, 8'(code));
            repeat (div_of(code) - 1) @(negedge clk);
            rd(1, d); chk("R3 before advance", d, 0);
            @(negedge clk);
            rd(1, d); chk("R3 first advance", d, 1);
        end

        // R4 free-running: no clear on match, wrap at 0xFF
        wr(0, 8'd0);
        wr(2, 8'h10);
        wr(1, 8'h0f);
        wr(0, mk_ctrl(1, 0, 0, 0));
        @(negedge clk); rd(1, d); chk("R4 reach cmpA", d, 8'h10);
        @(negedge clk); rd(1, d); chk("R4 pass cmpA", d, 8'h11);
        wr(0, 8'd0);
        wr(1, 8'hfe);
        wr(0, mk_ctrl(1, 0, 0, 0));
        @(negedge clk); rd(1, d); chk("R4 top", d, 8'hff);
        @(negedge clk); rd(1, d); chk("R4 wrap", d, 8'h00);

        // R5 clear-on-match, B match does not disturb the count
        wr(0, 8'd0);
        wr(1, 8'd0);
        wr(2, 8'd3);
        wr(3, 8'd1);
        wr(0, mk_ctrl(1, 1, 0, 0));
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            rd(1, d); chk("R5 period", d, (i + 1) % 4);
        end

        // R7 set on match on both channels
        wr(0, 8'd0);
        wr(1, 8'd0);
        wr(2, 8'd2);
        wr(3, 8'd0);
        wr(4, 8'h3);
        wr(0, mk_ctrl(1, 1, 3, 3));
        repeat (5) @(negedge clk);
        chk("R7 set A", wave_out[0], 1);
        chk("R7 set B", wave_out[1], 1);
        chk("R7 oe", wave_oe, 2'b11);
        // R7 clear on A, R8 B disconnected and holding
        wr(0, mk_ctrl(1, 1, 2, 0));
        repeat (5) @(negedge clk);
        chk("R7 clear A", wave_out[0], 0);
        chk("R8 oe B low", wave_oe[1], 0);
        chk("R8 B level held", wave_out[1], 1);

        // R9 flags set, W1C per bit, set wins over clear
        chk("R9 flags set", match_flag, 2'b11);
        wr(0, 8'd0);
        wr(4, 8'h1);
        chk("R9 clear A only", match_flag, 2'b10);
        wr(4, 8'h2);
        chk("R9 clear B", match_flag, 2'b00);
        wr(1, 8'd0);
        wr(2, 8'd0);
        wr(0, mk_ctrl(1, 1, 0, 0));
        @(negedge clk);
        wr(4, 8'h1);
        chk("R9 set wins", match_flag[0], 1);

        // R10 write overrides a running advance
        wr(0, 8'd0);
        wr(2, 8'hff);
        wr(0, mk_ctrl(1, 0, 0, 0));
        wr(1, 8'h80);
        rd(1, d); chk("R10 write value", d, 8'h80);
        @(negedge clk);
        rd(1, d); chk("R10 then advance", d, 8'h81);

        // R6 random toggle half-periods in clear-on-match mode
        for (int it = 0; it < 8; it++) begin
            int a, code, n;
            logic prev;
            a    = $urandom_range(0, 12);
            code = $urandom_range(1, 2);
            wr(0, 8'd0);
            wr(1, 8'd0);
            wr(2, 8'(a));
            wr(0, mk_ctrl(code, 1, 1, 0));
            prev = wave_out[0];
            n = 0;
            while (wave_out[0] == prev && n < 5000) begin
                @(negedge clk); n++;
            end
            prev = wave_out[0];
            n = 0;
            while (wave_out[0] == prev && n < 5000) begin
                @(negedge clk); n++;
            end
            chk("R6 half period", n, div_of(code) * (a + 1));
            chk("R6 oe", wave_oe[0], 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule